// File: doc/BRIEF.md
# Split-Decoding Iteration Sequencer

This block paces the iterations of a partially parallel LDPC decoder whose parity-check edges fall into two classes: structured edges, which are grouped into collision-free permutation submatrices, and a sparse set of random edges. Every decoding iteration runs as four ordered phases. The first two handle check nodes, on the structured edges and then on the random edges. The last two do the same for variable nodes. For each active cycle the sequencer tells the node processors which node role to take, which edge class to serve, whether to read or write, whether the access targets edge messages or the partial sums kept for the other class, and which slot within the current sub-step is being served.

Each phase is built from four sub-steps, and they run in a fixed order. The edge messages are read first, then the partial messages of the other class. After that the edge messages are written back, and last the element's own partial messages are updated. A read sub-step and a write sub-step never share a cycle, which suits single-port message banks. An edge sub-step lasts as many cycles as the element's count for that edge class. A partial sub-step lasts one cycle for each node of the current role that the element serves. The four counts and the iteration count are taken in when a start request is accepted. The sequencer then repeats the four-phase iteration until the programmed number of iterations has completed, and after that it raises a one-cycle done pulse.

The controller has three states. IDLE waits for a request; the transition IDLE->RUN is taken on `start_req`. RUN produces one schedule slot per cycle. The transition RUN->DONE is taken on the last slot of the last iteration, and otherwise RUN stays in RUN. DONE lasts one cycle and always returns through DONE->IDLE.

Top module: `split_iter_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `busy`, `active`, `done`, `phase`, `rw`, `part_sel`, `step_idx` and `iter_idx` are all zero.
- R2: Within an iteration the phases follow the order check/structured, check/random, variable/structured, variable/random. `phase` encodes these as 0, 1, 2 and 3: bit 1 set means variable-node role and bit 0 set means random edges. `node_mode` equals `phase[1]` and `edge_class` equals `phase[0]`.
- R3: Each phase runs four sub-steps in the order edge read, partial read, edge write, partial write. `rw` is 0 for the reads and 1 for the writes. `part_sel` is 0 for edge accesses and 1 for partial accesses.
- R4: An edge sub-step lasts `cfg_sub_cnt` cycles in a structured phase and `cfg_rand_cnt` cycles in a random phase. A partial sub-step lasts `cfg_cn_cnt` cycles in a check phase and `cfg_vn_cnt` cycles in a variable phase. `step_idx` counts 0 up to the length minus one within each sub-step.
- R5: A node or edge count programmed as zero is served as a count of one.
- R6: `cfg_iters` sets the number of iterations, and a value of zero selects the default of 10. `iter_idx` holds the index of the current iteration, counting from 0.
- R7: `done` is high for exactly one cycle, the cycle right after the last active cycle of the last iteration. The sequencer is idle in the cycle that follows.
- R8: A `start_req` seen while `busy` is high, including in the cycle of the done pulse, is ignored. It neither restarts nor prolongs the run.
- R9: The counts and the iteration number are captured when a start is accepted, and changing the configuration inputs during a run has no effect on the schedule.
- R10: A start request seen in IDLE makes the next cycle the first active cycle: phase 0, edge read, `step_idx` 0, `iter_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to begin a decoding run |
| cfg_sub_cnt | input | CNT_W | Structured submatrices handled per element |
| cfg_rand_cnt | input | CNT_W | Random edges handled per element |
| cfg_cn_cnt | input | CNT_W | Check nodes served per element |
| cfg_vn_cnt | input | CNT_W | Variable nodes served per element |
| cfg_iters | input | ITER_W | Iteration count, 0 selects the default |
| busy | output | 1 | Run in progress (RUN or DONE) |
| active | output | 1 | A schedule slot is being issued this cycle |
| phase | output | 2 | Current phase code |
| node_mode | output | 1 | 0 check-node role, 1 variable-node role |
| edge_class | output | 1 | 0 structured edges, 1 random edges |
| rw | output | 1 | 0 read sub-step, 1 write sub-step |
| part_sel | output | 1 | 0 edge messages, 1 partial messages |
| step_idx | output | CNT_W | Slot index within the current sub-step |
| iter_idx | output | ITER_W | Current iteration index |
| done | output | 1 | One-cycle completion pulse |

## Verification
The collision of interest is a new start request that falls in the same cycle as the done pulse, and this cycle is the one where the sequencer is closest to accepting it. The bench drives `start_req` high in exactly that cycle at the end of every job. It then expects `busy` low and no active slot in the next cycle, which shows the request was dropped rather than queued. During each run the bench also raises stray start pulses and scrambles the configuration inputs. It compares every issued slot against a schedule built independently from the captured counts, so any restart or change in length shows up as a mismatch.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } seq_state_e;

    // bit 1: variable-node role, bit 0: random edge class
    typedef enum logic [1:0] {
        PH_CHK_STR = 2'd0,
        PH_CHK_RND = 2'd1,
        PH_VAR_STR = 2'd2,
        PH_VAR_RND = 2'd3
    } phase_e;

    // bit 1: write, bit 0: partial-message access
    typedef enum logic [1:0] {
        ST_EDGE_RD = 2'd0,
        ST_PART_RD = 2'd1,
        ST_EDGE_WR = 2'd2,
        ST_PART_WR = 2'd3
    } step_e;

endpackage

// File: rtl/seq_cfg_capture.sv
module seq_cfg_capture #(
    parameter int CNT_W     = 8,
    parameter int ITER_W    = 5,
    parameter int DEF_ITERS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  in_sub,
    input  logic [CNT_W-1:0]  in_rnd,
    input  logic [CNT_W-1:0]  in_cn,
    input  logic [CNT_W-1:0]  in_vn,
    input  logic [ITER_W-1:0] in_iters,
    output logic [CNT_W-1:0]  sub_q,
    output logic [CNT_W-1:0]  rnd_q,
    output logic [CNT_W-1:0]  cn_q,
    output logic [CNT_W-1:0]  vn_q,
    output logic [ITER_W-1:0] iters_q
);
    localparam logic [CNT_W-1:0]  ONE_C   = CNT_W'(1);
    localparam logic [ITER_W-1:0] DEF_ITV = ITER_W'(DEF_ITERS);

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE_C : v;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= ONE_C;
            rnd_q   <= ONE_C;
            cn_q    <= ONE_C;
            vn_q    <= ONE_C;
            iters_q <= DEF_ITV;
        end else if (load) begin
            sub_q   <= at_least_one(in_sub);
            rnd_q   <= at_least_one(in_rnd);
            cn_q    <= at_least_one(in_cn);
            vn_q    <= at_least_one(in_vn);
            iters_q <= (in_iters == '0) ? DEF_ITV : in_iters;
        end
    end

    // R9: captured configuration only moves on an accepted start
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sub_q) && $stable(rnd_q) && $stable(cn_q)
                   && $stable(vn_q) && $stable(iters_q)));

endmodule

// File: rtl/seq_step_len.sv
module seq_step_len
    import seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  phase_e           phase,
    input  step_e            step,
    input  logic [CNT_W-1:0] sub_cnt,
    input  logic [CNT_W-1:0] rnd_cnt,
    input  logic [CNT_W-1:0] cn_cnt,
    input  logic [CNT_W-1:0] vn_cnt,
    output logic [CNT_W-1:0] len
);
    logic edge_access;
    logic [CNT_W-1:0] edge_len;
    logic [CNT_W-1:0] node_len;

    always_comb begin
        edge_access = (step == ST_EDGE_RD) || (step == ST_EDGE_WR);
        edge_len    = phase[0] ? rnd_cnt : sub_cnt;
        node_len    = phase[1] ? vn_cnt  : cn_cnt;
        len         = edge_access ? edge_len : node_len;
    end

endmodule

// File: rtl/seq_iter_ctr.sv
module seq_iter_ctr #(
    parameter int ITER_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    input  logic [ITER_W-1:0] total,
    output logic [ITER_W-1:0] idx,
    output logic              last
);
    localparam logic [ITER_W-1:0] ONE_I = ITER_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + ONE_I;
        end
    end

    assign last = (idx == total - ONE_I);

endmodule

// File: rtl/split_iter_seq.sv
module split_iter_seq
    import seq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int ITER_W    = 5,
    parameter int DEF_ITERS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [CNT_W-1:0]  cfg_sub_cnt,
    input  logic [CNT_W-1:0]  cfg_rand_cnt,
    input  logic [CNT_W-1:0]  cfg_cn_cnt,
    input  logic [CNT_W-1:0]  cfg_vn_cnt,
    input  logic [ITER_W-1:0] cfg_iters,
    output logic              busy,
    output logic              active,
    output logic [1:0]        phase,
    output logic              node_mode,
    output logic              edge_class,
    output logic              rw,
    output logic              part_sel,
    output logic [CNT_W-1:0]  step_idx,
    output logic [ITER_W-1:0] iter_idx,
    output logic              done
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    seq_state_e        state_q, state_d;
    phase_e            phase_q, phase_d;
    step_e             step_q,  step_d;
    logic [CNT_W-1:0]  idx_q,   idx_d;

    logic              cfg_load;
    logic              iter_clear;
    logic              iter_inc;
    logic              iter_last;
    logic [ITER_W-1:0] iter_cur;
    logic [ITER_W-1:0] iter_total;
    logic [CNT_W-1:0]  sub_c, rnd_c, cn_c, vn_c;
    logic [CNT_W-1:0]  cur_len;
    logic              slot_last;

    seq_cfg_capture #(
        .CNT_W    (CNT_W),
        .ITER_W   (ITER_W),
        .DEF_ITERS(DEF_ITERS)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .in_sub  (cfg_sub_cnt),
        .in_rnd  (cfg_rand_cnt),
        .in_cn   (cfg_cn_cnt),
        .in_vn   (cfg_vn_cnt),
        .in_iters(cfg_iters),
        .sub_q   (sub_c),
        .rnd_q   (rnd_c),
        .cn_q    (cn_c),
        .vn_q    (vn_c),
        .iters_q (iter_total)
    );

    seq_step_len #(.CNT_W(CNT_W)) i_len (
        .phase  (phase_q),
        .step   (step_q),
        .sub_cnt(sub_c),
        .rnd_cnt(rnd_c),
        .cn_cnt (cn_c),
        .vn_cnt (vn_c),
        .len    (cur_len)
    );

    seq_iter_ctr #(.ITER_W(ITER_W)) i_iter (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(iter_clear),
        .inc  (iter_inc),
        .total(iter_total),
        .idx  (iter_cur),
        .last (iter_last)
    );

    assign slot_last = (idx_q == cur_len - ONE_C);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_CHK_STR;
            step_q  <= ST_EDGE_RD;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            step_q  <= step_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        phase_d    = phase_q;
        step_d     = step_q;
        idx_d      = idx_q;
        cfg_load   = 1'b0;
        iter_clear = 1'b0;
        iter_inc   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_req) begin
                    state_d    = S_RUN;
                    cfg_load   = 1'b1;
                    iter_clear = 1'b1;
                    phase_d    = PH_CHK_STR;
                    step_d     = ST_EDGE_RD;
                    idx_d      = '0;
                end
            end
            S_RUN: begin
                if (!slot_last) begin
                    idx_d = idx_q + ONE_C;
                end else begin
                    idx_d = '0;
                    if (step_q != ST_PART_WR) begin
                        step_d = step_e'(step_q + 2'd1);
                    end else begin
                        step_d = ST_EDGE_RD;
                        if (phase_q != PH_VAR_RND) begin
                            phase_d = phase_e'(phase_q + 2'd1);
                        end else begin
                            phase_d = PH_CHK_STR;
                            if (iter_last) begin
                                state_d = S_DONE;
                            end else begin
                                iter_inc = 1'b1;
                            end
                        end
                    end
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        active     = (state_q == S_RUN);
        done       = (state_q == S_DONE);
        phase      = phase_q;
        node_mode  = phase_q[1];
        edge_class = phase_q[0];
        rw         = step_q[1];
        part_sel   = step_q[0];
        step_idx   = idx_q;
        iter_idx   = iter_cur;
    end

    // R2: a phase change inside a run always moves to the next code
    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (phase != $past(phase)))
            |-> (phase == 2'($past(phase) + 2'd1)));

    // R3: sub-step changes advance by one in the fixed order
    a_r3_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && ({rw, part_sel} != $past({rw, part_sel})))
            |-> ({rw, part_sel} == 2'($past({rw, part_sel}) + 2'd1)));

    // R4: slot index stays inside the sub-step length
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (step_idx < cur_len));

    // R6: iteration index stays below the captured count
    a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (iter_idx < iter_total));

    // R7: done is a single pulse that follows an active cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(active));

    // R8: a request while running keeps the run going, none restarts after done
    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && !done) |=> busy);
    a_r8_done_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: an accepted request opens the first slot next cycle
    a_r10_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> (active && (phase == 2'd0) && !rw && !part_sel
                                  && (step_idx == '0) && (iter_idx == '0)));

endmodule

// File: tb/test_split_iter_seq.sv
module test_split_iter_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int ITER_W     = 5;
    localparam int DEF_ITERS  = 10;
    localparam int WATCHDOG   = 150000;

    logic              clk;
    logic              rst_n;
    logic              start_req;
    logic [CNT_W-1:0]  cfg_sub_cnt, cfg_rand_cnt, cfg_cn_cnt, cfg_vn_cnt;
    logic [ITER_W-1:0] cfg_iters;
    logic              busy, active, node_mode, edge_class, rw, part_sel, done;
    logic [1:0]        phase;
    logic [CNT_W-1:0]  step_idx;
    logic [ITER_W-1:0] iter_idx;

    int vectors = 0;
    int fails   = 0;

    split_iter_seq #(
        .CNT_W(CNT_W), .ITER_W(ITER_W), .DEF_ITERS(DEF_ITERS)
    ) i_split_iter_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .cfg_sub_cnt(cfg_sub_cnt), .cfg_rand_cnt(cfg_rand_cnt),
        .cfg_cn_cnt(cfg_cn_cnt), .cfg_vn_cnt(cfg_vn_cnt), .cfg_iters(cfg_iters),
        .busy(busy), .active(active), .phase(phase), .node_mode(node_mode),
        .edge_class(edge_class), .rw(rw), .part_sel(part_sel),
        .step_idx(step_idx), .iter_idx(iter_idx), .done(done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // R4/R5: sub-step length from the phase, sub-step and programmed counts
    function automatic int exp_len(input int ph, input int st,
                                   input int s, input int r, input int c, input int v);
        if (st == 0 || st == 2) return (ph % 2 == 1) ? clamp1(r) : clamp1(s);
        return (ph >= 2) ? clamp1(v) : clamp1(c);
    endfunction

    function automatic int exp_iters(input int it);
        return (it == 0) ? DEF_ITERS : it;
    endfunction

    task automatic scramble_inputs();
        start_req    = 1'($urandom_range(0, 1));
        cfg_sub_cnt  = CNT_W'($urandom_range(0, 9));
        cfg_rand_cnt = CNT_W'($urandom_range(0, 9));
        cfg_cn_cnt   = CNT_W'($urandom_range(0, 9));
        cfg_vn_cnt   = CNT_W'($urandom_range(0, 9));
        cfg_iters    = ITER_W'($urandom_range(0, 31));
    endtask

    task automatic run_job(input int s, input int r, input int c, input int v,
                           input int it, input bit disturb);
        int n_it;
        n_it = exp_iters(it);
        @(negedge clk);
        cfg_sub_cnt  = CNT_W'(s);
        cfg_rand_cnt = CNT_W'(r);
        cfg_cn_cnt   = CNT_W'(c);
        cfg_vn_cnt   = CNT_W'(v);
        cfg_iters    = ITER_W'(it);
        start_req    = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int k = 0; k < n_it; k++) begin
            for (int ph = 0; ph < 4; ph++) begin
                for (int st = 0; st < 4; st++) begin
                    for (int i = 0; i < exp_len(ph, st, s, r, c, v); i++) begin
                        if (k == 0 && ph == 0 && st == 0 && i == 0)
                            chk("R10", "first slot active", int'(active), 1);
                        chk("R8", "busy in run", int'(busy), 1);
                        chk("R2", "phase", int'(phase), ph);
                        chk("R2", "mode/class", int'({node_mode, edge_class}), ph);
                        chk("R3", "rw/part", int'({rw, part_sel}), st);
                        chk("R4", "step_idx", int'(step_idx), i);
                        chk("R6", "iter_idx", int'(iter_idx), k);
                        // R8/R9: stray starts and config changes during the run
                        if (disturb) scramble_inputs();
                        @(negedge clk);
                    end
                end
            end
        end
        chk("R7", "done pulse", int'(done), 1);
        chk("R7", "active at done", int'(active), 0);
        start_req = 1'b1;           // R8: request in the done cycle
        @(negedge clk);
        start_req = 1'b0;
        chk("R7", "done cleared", int'(done), 0);
        chk("R8", "start at done ignored", int'(busy), 0);
        chk("R8", "no slot after done", int'(active), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        start_req = 1'b0;
        cfg_sub_cnt = '0; cfg_rand_cnt = '0; cfg_cn_cnt = '0; cfg_vn_cnt = '0;
        cfg_iters = '0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "slot fields in reset",
            int'({active, phase, rw, part_sel, step_idx, iter_idx}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", int'({busy, active, done}), 0);

        // directed corner cases
        run_job(2, 3, 1, 2, 1, 1'b0);     // single iteration
        run_job(1, 1, 1, 1, 0, 1'b0);     // R6: default count
        run_job(0, 0, 0, 0, 2, 1'b0);     // R5: zero counts
        run_job(3, 0, 4, 0, 14, 1'b1);    // R6: 14 iterations, R9 disturbed
        run_job(1, 5, 2, 3, 3, 1'b1);

        for (int j = 0; j < 12; j++) begin
            run_job(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                    int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                    int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule